// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns a pair of stereo samples into a serial bit stream with a matching word clock, for an audio bus driven by a shared bit clock. The bit clock itself is generated elsewhere. The block sees it as `bclk_en`, a one-cycle pulse in the system clock domain at each falling bit-clock edge. Each pulse moves the transmitter to the next bit slot and updates both outputs. The data is therefore stable before the next rising edge, where a receiver samples it.

A frame is 64 slots long, with 32 slots per channel. A 2-bit format field selects one of four alignments of data against the word clock: I2S, DSP (single-slot frame pulse, left then right back to back), right-justified and left-justified. The word length is 16, 20, 24 or 32 bits. A slot offset delays where the data starts, so several transmitters can take turns on the same data line. The format, length, offset and both samples are captured once per frame, on the pulse that enters slot 0. Changes made during a frame wait for the next one.

Top module: `aud_serial_tx`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first `bclk_en` pulse, `wclk` and `sdata` are 0. The first pulse puts the transmitter in slot 0 of a new frame.
- R2: `wclk` and `sdata` change only in the cycle after a `bclk_en` pulse, and they hold their value in every cycle without a pulse.
- R3: A frame is 64 slots, numbered 0 to 63. Slots 0 to 31 are the left half and 32 to 63 are the right half. After slot 63 the next pulse returns to slot 0.
- R4: The format field `fmt_sel` is coded 00 = I2S, 01 = DSP, 10 = right-justified and 11 = left-justified. `wclk` depends on the format:
  - I2S: 0 in the left half and 1 in the right half.
  - Right-justified and left-justified: 1 in the left half and 0 in the right half.
  - DSP: 1 in slot 0 only.
- R5: In I2S, each channel's MSB is in slot 1 + offset of its half, one slot after the word-clock edge. The remaining bits follow MSB first.
- R6: In left-justified format, each channel's MSB is in slot `offset` of its half, so with offset 0 it sits at the word-clock edge. The remaining bits follow MSB first.
- R7: In right-justified format with offset 0, each channel's LSB is in the last slot of its half (31 or 63). A non-zero offset moves the word later by that many slots. Bits pushed past the end of the half are not sent.
- R8: In DSP format, the left MSB is in slot `offset`. The right MSB follows the left LSB directly, in slot offset + L. Bits that would fall past slot 63 are not sent.
- R9: `wlen_sel` is coded 00 = 16, 01 = 20, 10 = 24 and 11 = 32 bits, which sets the word length L. The sent word is bits [L-1:0] of each sample. Sample bits above L-1 have no effect on `sdata`.
- R10: Every slot that carries no sample bit drives `sdata` = 0.
- R11: The format, length, offset (`slot_off`, 0 to 31 slots) and both samples are captured only on the pulse that enters slot 0. Changes during slots 1 to 63 do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_en | input | 1 | One-cycle pulse at each falling bit-clock edge |
| fmt_sel | input | 2 | Frame format code |
| wlen_sel | input | 2 | Word length code |
| slot_off | input | OFF_W (5) | Data start offset in bit slots |
| left_smp | input | SAMPLE_W (32) | Left channel sample, LSB-aligned |
| right_smp | input | SAMPLE_W (32) | Right channel sample, LSB-aligned |
| wclk | output | 1 | Word clock |
| sdata | output | 1 | Serial data |

## Verification
A wrong slot count or a bad wrap shows at the ports within one frame as a word-clock edge in the wrong slot. A wrong start position or length shows as data bits displaced by whole slots, or as ones where zeros belong. Configuration captured at the wrong time corrupts the rest of the frame that follows the mid-frame change. The bench sweeps every format, every word length and four offsets, including ones that push bits off the end of a half. It changes the inputs in the middle of every frame, and it compares both outputs in every slot against a model that computes the expected values arithmetically. Any such fault is therefore reported in the slot where it first appears.

// File: rtl/aud_tx_pkg.sv
// Package: shared types and helpers for the audio serial transmitter.
// Assumes word lengths are limited to the four codes below.
package aud_tx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_DSP = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_LJ  = 2'b11
    } fmt_e;

    // Converts the 2-bit length code to a bit count.
    function automatic int wlen_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 20;
            2'b10:   return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/aud_tx_frame_ctl.sv
// Frame control: keeps the slot counter and the per-frame copy of the
// configuration and samples. It presents the slot that the next pulse will
// enter, along with the configuration that applies to that slot. On the
// pulse that wraps to slot 0, the live inputs are shown directly, so the
// first slot of a frame already uses the new values.
// Assumes bclk_en is a single-cycle pulse.
module aud_tx_frame_ctl
    import aud_tx_pkg::*;
#(
    parameter int SLOT_W   = 32,
    parameter int OFF_W    = 5,
    parameter int SAMPLE_W = 32,
    localparam int CNT_W   = $clog2(2 * SLOT_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_en,
    input  fmt_e                fmt_in,
    input  logic [1:0]          len_in,
    input  logic [OFF_W-1:0]    off_in,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    output logic [CNT_W-1:0]    slot_nxt,
    output fmt_e                fmt_v,
    output logic [1:0]          len_v,
    output logic [OFF_W-1:0]    off_v,
    output logic [SAMPLE_W-1:0] left_v,
    output logic [SAMPLE_W-1:0] right_v
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * SLOT_W - 1);

    logic [CNT_W-1:0]    cnt_q;
    fmt_e                fmt_q;
    logic [1:0]          len_q;
    logic [OFF_W-1:0]    off_q;
    logic [SAMPLE_W-1:0] left_q;
    logic [SAMPLE_W-1:0] right_q;
    logic                wrap;

    // Works out the next slot and which configuration applies to it.
    always_comb begin
        wrap     = (cnt_q == LAST);
        slot_nxt = wrap ? '0 : cnt_q + 1'b1;
        fmt_v    = wrap ? fmt_in   : fmt_q;
        len_v    = wrap ? len_in   : len_q;
        off_v    = wrap ? off_in   : off_q;
        left_v   = wrap ? left_in  : left_q;
        right_v  = wrap ? right_in : right_q;
    end

    // Advances the slot counter on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= LAST;
        else if (bclk_en) cnt_q <= slot_nxt;
    end

    // Captures the configuration and samples on the pulse that enters slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q   <= FMT_I2S;
            len_q   <= 2'b00;
            off_q   <= '0;
            left_q  <= '0;
            right_q <= '0;
        end else if (bclk_en && wrap) begin
            fmt_q   <= fmt_in;
            len_q   <= len_in;
            off_q   <= off_in;
            left_q  <= left_in;
            right_q <= right_in;
        end
    end

    p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_en && cnt_q == LAST) |=> (cnt_q == '0));

    p_count_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_en |=> $stable(cnt_q));

    p_cfg_frame_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_en && cnt_q == LAST) |=>
            ($stable(fmt_q) && $stable(len_q) && $stable(off_q)
             && $stable(left_q) && $stable(right_q)));

endmodule

// File: rtl/aud_tx_slot_map.sv
// Slot map: a combinational block that decides, for a given slot and
// configuration, the word-clock level, whether the slot carries a sample bit,
// and if so which channel and which bit index.
// Assumes SLOT_W >= 32, so every supported word fits in one half.
module aud_tx_slot_map
    import aud_tx_pkg::*;
#(
    parameter int SLOT_W   = 32,
    parameter int OFF_W    = 5,
    parameter int SAMPLE_W = 32,
    localparam int CNT_W   = $clog2(2 * SLOT_W),
    localparam int IDX_W   = $clog2(SAMPLE_W)
) (
    input  logic [CNT_W-1:0] slot,
    input  fmt_e             fmt,
    input  logic [1:0]       len_code,
    input  logic [OFF_W-1:0] off,
    output logic             wclk_d,
    output logic             bit_valid,
    output logic             ch_right,
    output logic [IDX_W-1:0] bit_idx
);

    int  len;
    int  s;
    int  o;
    int  pos;
    int  start;
    int  k;
    int  idx_i;
    logic half;

    // Maps the slot to the word-clock level and the sample bit it carries.
    always_comb begin
        len       = wlen_bits(len_code);
        s         = int'(slot);
        o         = int'(off);
        half      = (s >= SLOT_W);
        pos       = half ? (s - SLOT_W) : s;
        start     = 0;
        k         = 0;
        idx_i     = 0;
        bit_valid = 1'b0;
        ch_right  = 1'b0;
        case (fmt)
            FMT_I2S: wclk_d = half;
            FMT_DSP: wclk_d = (s == 0);
            default: wclk_d = !half;
        endcase
        if (fmt == FMT_DSP) begin
            k = s - o;
            if (k >= 0 && k < len) begin
                bit_valid = 1'b1;
                idx_i     = len - 1 - k;
            end else if (k >= len && k < 2 * len) begin
                bit_valid = 1'b1;
                ch_right  = 1'b1;
                idx_i     = 2 * len - 1 - k;
            end
        end else begin
            case (fmt)
                FMT_I2S: start = o + 1;
                FMT_LJ:  start = o;
                default: start = SLOT_W - len + o;
            endcase
            k = pos - start;
            if (k >= 0 && k < len) begin
                bit_valid = 1'b1;
                ch_right  = half;
                idx_i     = len - 1 - k;
            end
        end
        bit_idx = IDX_W'(idx_i);
    end

endmodule

// File: rtl/aud_tx_serializer.sv
// Serializer: the output register stage. On each pulse it loads the word-clock
// level and the selected sample bit, or zero when the slot is unused. Both
// outputs hold between pulses.
// Assumes that when bit_valid is high, bit_idx is below the word length.
module aud_tx_serializer #(
    parameter int SAMPLE_W = 32,
    localparam int IDX_W   = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                wclk_d,
    input  logic                bit_valid,
    input  logic                ch_right,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic [SAMPLE_W-1:0] left_v,
    input  logic [SAMPLE_W-1:0] right_v,
    output logic                wclk_q,
    output logic                sdata_q
);

    logic [SAMPLE_W-1:0] word_sel;
    logic                bit_d;

    // Picks the channel, then the bit within it.
    always_comb begin
        word_sel = ch_right ? right_v : left_v;
        bit_d    = bit_valid ? word_sel[bit_idx] : 1'b0;
    end

    // Loads both outputs on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wclk_q  <= 1'b0;
            sdata_q <= 1'b0;
        end else if (adv) begin
            wclk_q  <= wclk_d;
            sdata_q <= bit_d;
        end
    end

    p_hold_between_pulses_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(wclk_q) && $stable(sdata_q)));

    p_unused_slot_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !bit_valid) |=> !sdata_q);

endmodule

// File: rtl/aud_serial_tx.sv
// Top level of the multi-format audio serial transmitter. It connects the frame
// control, the slot map and the output serializer.
// Assumes bclk_en is a one-cycle pulse at each falling bit-clock edge, with at
// least one idle cycle between pulses.
module aud_serial_tx
    import aud_tx_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int SLOT_W   = 32,
    parameter int OFF_W    = 5,
    localparam int CNT_W   = $clog2(2 * SLOT_W),
    localparam int IDX_W   = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_en,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          wlen_sel,
    input  logic [OFF_W-1:0]    slot_off,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    output logic                wclk,
    output logic                sdata
);

    logic [CNT_W-1:0]    slot_nxt;
    fmt_e                fmt_v;
    logic [1:0]          len_v;
    logic [OFF_W-1:0]    off_v;
    logic [SAMPLE_W-1:0] left_v;
    logic [SAMPLE_W-1:0] right_v;
    logic                wclk_d;
    logic                bit_valid;
    logic                ch_right;
    logic [IDX_W-1:0]    bit_idx;

    aud_tx_frame_ctl #(
        .SLOT_W   (SLOT_W),
        .OFF_W    (OFF_W),
        .SAMPLE_W (SAMPLE_W)
    ) i_frame_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_en  (bclk_en),
        .fmt_in   (fmt_e'(fmt_sel)),
        .len_in   (wlen_sel),
        .off_in   (slot_off),
        .left_in  (left_smp),
        .right_in (right_smp),
        .slot_nxt (slot_nxt),
        .fmt_v    (fmt_v),
        .len_v    (len_v),
        .off_v    (off_v),
        .left_v   (left_v),
        .right_v  (right_v)
    );

    aud_tx_slot_map #(
        .SLOT_W   (SLOT_W),
        .OFF_W    (OFF_W),
        .SAMPLE_W (SAMPLE_W)
    ) i_slot_map (
        .slot      (slot_nxt),
        .fmt       (fmt_v),
        .len_code  (len_v),
        .off       (off_v),
        .wclk_d    (wclk_d),
        .bit_valid (bit_valid),
        .ch_right  (ch_right),
        .bit_idx   (bit_idx)
    );

    aud_tx_serializer #(
        .SAMPLE_W (SAMPLE_W)
    ) i_serializer (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (bclk_en),
        .wclk_d    (wclk_d),
        .bit_valid (bit_valid),
        .ch_right  (ch_right),
        .bit_idx   (bit_idx),
        .left_v    (left_v),
        .right_v   (right_v),
        .wclk_q    (wclk),
        .sdata_q   (sdata)
    );

    p_dsp_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_en && fmt_v == FMT_DSP && slot_nxt != '0) |=> !wclk);

    p_i2s_right_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_en && fmt_v == FMT_I2S) |=> (wclk == $past(slot_nxt[CNT_W-1])));

endmodule

// File: tb/test_aud_serial_tx.sv
// Bench: sweeps every format, every word length and four offsets. Inputs change
// in the middle of every frame. Both outputs are compared in every slot against
// an arithmetic model.
module test_aud_serial_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_en = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [1:0]  wlen_sel = 2'b00;
    logic [4:0]  slot_off = '0;
    logic [31:0] left_smp = '0;
    logic [31:0] right_smp = '0;
    logic        wclk;
    logic        sdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    aud_serial_tx i_aud_serial_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_en   (bclk_en),
        .fmt_sel   (fmt_sel),
        .wlen_sel  (wlen_sel),
        .slot_off  (slot_off),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .wclk      (wclk),
        .sdata     (sdata)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic int len_of(input int c);
        return (c == 0) ? 16 : (c == 1) ? 20 : (c == 2) ? 24 : 32;
    endfunction

    function automatic int off_of(input int f);
        int t;
        t = (f / 16) % 4;
        return (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 5 : 17;
    endfunction

    function automatic logic [31:0] lsmp(input int f);
        return 32'h9E37_79B9 * (f + 1) ^ 32'h1234_5678;
    endfunction

    function automatic logic [31:0] rsmp(input int f);
        return 32'h85EB_CA6B * (f + 3) ^ 32'hC0DE_F00D;
    endfunction

    function automatic logic exp_wc(input int s, input int m);
        if (m == 0) return (s >= 32);
        if (m == 1) return (s == 0);
        return (s < 32);
    endfunction

    // Returns -1 for an empty slot; otherwise the bit value.
    function automatic int exp_sd(input int s, input int m, input int L, input int o,
                                  input logic [31:0] l, input logic [31:0] r);
        int p, k, st;
        if (m == 1) begin
            k = s - o;
            if (k >= 0 && k < L) return int'(l[L-1-k]);
            if (k >= L && k < 2 * L) return int'(r[2*L-1-k]);
            return -1;
        end
        p  = s % 32;
        st = (m == 0) ? o + 1 : (m == 3) ? o : 32 - L + o;
        k  = p - st;
        if (k < 0 || k >= L) return -1;
        return (s < 32) ? int'(l[L-1-k]) : int'(r[L-1-k]);
    endfunction

    task automatic apply_cfg(input int f);
        fmt_sel   = 2'(f % 4);
        wlen_sel  = 2'((f / 4) % 4);
        slot_off  = 5'(off_of(f));
        left_smp  = lsmp(f);
        right_smp = rsmp(f);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic wc0, sd0;
        int e;
        string rq;
        apply_cfg(0);
        repeat (5) @(negedge clk);
        chk(wclk, 1'b0, "R1 wclk in reset");
        chk(sdata, 1'b0, "R1 sdata in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(wclk, 1'b0, "R1 wclk before first pulse");
        chk(sdata, 1'b0, "R1 sdata before first pulse");
        for (int f = 0; f < 64; f++) begin
            for (int s = 0; s < 64; s++) begin
                @(negedge clk) bclk_en = 1'b1;
                @(negedge clk) bclk_en = 1'b0;
                wc0 = wclk;
                sd0 = sdata;
                chk(wc0, exp_wc(s, f % 4), "R4/R3 wclk level");
                e = exp_sd(s, f % 4, len_of((f / 4) % 4), off_of(f), lsmp(f), rsmp(f));
                case (f % 4)
                    0: rq = "R5/R9/R11 I2S data";
                    1: rq = "R8/R9/R11 DSP data";
                    2: rq = "R7/R9/R11 right-justified data";
                    default: rq = "R6/R9/R11 left-justified data";
                endcase
                if (e < 0) chk(sd0, 1'b0, "R10 unused slot");
                else chk(sd0, e[0], rq);
                if (s == 40) apply_cfg(f + 1);
                @(negedge clk);
                @(negedge clk);
                chk(wclk, wc0, "R2 wclk hold");
                chk(sdata, sd0, "R2 sdata hold");
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule